// File: doc/BRIEF.md
# Sign-Bit Outer-Product Correlator

This block accumulates the auto-correlation outer product of an eight-element vector of sign bits into an 8×8 array of signed 8-bit counters. Each vector element is a single bit that stands for +1 or -1. The block does not use a multiplier. It builds two 64-bit patterns from the vector. One pattern is the whole vector laid down eight times. The other is each element broadcast eight times. The XNOR of the two patterns gives all 64 pairwise sign products. Each product bit then steps its counter by one, up or down.

The update runs one row per cycle, so a whole vector takes eight cycles. A strobe starts an update and a status flag shows that it is running. A one-cycle pulse marks its end. A clear input empties the array. A registered read port returns one row of eight counters, selected by a row index.

Top module: `sbop_corr`

## Requirements
- R1: Input bit 1 means +1 and bit 0 means -1. One update moves the counter at row k, lane j by +1 when `vec_in[k]` equals `vec_in[j]`, and by -1 otherwise.
- R2: A start that is accepted raises `busy` on the next cycle and holds it for exactly 8 cycles. `done` is high for exactly one cycle, the cycle right after the last busy cycle.
- R3: A start that arrives while `busy` is high is ignored. It does not change the counters, does not lengthen the update and does not begin a second update.
- R4: A counter that is at +127 stays at +127 when it is told to increment.
- R5: A counter that is at -128 stays at -128 when it is told to decrement.
- R6: `clr` zeroes all 64 counters on the next edge. It aborts a running update: `busy` drops, and no `done` pulse follows. `clr` has priority over `start`.
- R7: `rd_data` is registered. One cycle after `rd_row` is presented, `rd_data` holds that row. Bits [8j+7:8j] hold lane j as a two's-complement value.
- R8: After reset all counters are zero, `busy` and `done` are low, and `rd_data` is zero.
- R9: Successive updates add up. Each counter equals the saturated running sum of its ±1 steps since the last clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Zero all counters and abort any update |
| start | input | 1 | Begin an update with `vec_in` (accepted only when idle) |
| vec_in | input | 8 | Sign-bit vector, 1 = +1, 0 = -1 |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse when an update finishes |
| rd_row | input | 3 | Row index for the read port |
| rd_data | output | 64 | Eight signed 8-bit lanes of the selected row |

## Verification
The vector sequence includes all-ones and all-zeros, which make every product +1. It includes alternating patterns (A5, 3C) and a patterned vector (81), which spread agreements and disagreements unevenly across rows. A vector with a half split (0F) gives one sign in the diagonal quadrants and the opposite sign off them. Comparing every lane after each update shows whether row order, lane order and product sign are correct. Repeating all-ones and the half-split vector past 128 updates drives every lane to +127, or to a quadrant pattern of +127 and -128, which shows whether saturation works in both directions. A start injected in the middle of an update and a clear issued in the middle of an update show whether the sequencer ignores the first and is cancelled by the second.

// File: rtl/sbop_pkg.sv
package sbop_pkg;
    localparam int VLEN_DEF = 8;
    localparam int CW_DEF   = 8;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/sbop_expand.sv
module sbop_expand #(
    parameter int VLEN = 8
) (
    input  logic [VLEN-1:0]      vec,
    output logic [VLEN*VLEN-1:0] prod
);
    logic [VLEN*VLEN-1:0] rep_pat;
    logic [VLEN*VLEN-1:0] bc_pat;

    for (genvar i = 0; i < VLEN; i++) begin : g_row
        for (genvar j = 0; j < VLEN; j++) begin : g_col
            // whole vector repeated; element i broadcast across the group
            assign rep_pat[i*VLEN + j] = vec[j];
            assign bc_pat[i*VLEN + j]  = vec[i];
        end
    end

    assign prod = ~(rep_pat ^ bc_pat);
endmodule

// File: rtl/sbop_lane.sv
module sbop_lane #(
    parameter int CW = 8
) (
    input  logic [CW-1:0] cur,
    input  logic          up,
    output logic [CW-1:0] nxt
);
    localparam logic [CW-1:0] MAXV = {1'b0, {(CW-1){1'b1}}};
    localparam logic [CW-1:0] MINV = {1'b1, {(CW-1){1'b0}}};

    always_comb begin
        if (up) begin
            nxt = (cur == MAXV) ? cur : cur + 1'b1;
        end else begin
            nxt = (cur == MINV) ? cur : cur - 1'b1;
        end
    end
endmodule

// File: rtl/sbop_corr.sv
module sbop_corr
    import sbop_pkg::*;
#(
    parameter int VLEN = VLEN_DEF,
    parameter int CW   = CW_DEF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          start,
    input  logic [VLEN-1:0]               vec_in,
    output logic                          busy,
    output logic                          done,
    input  logic [$clog2(VLEN)-1:0]       rd_row,
    output logic [VLEN*CW-1:0]            rd_data
);
    localparam int RW   = $clog2(VLEN);
    localparam int ROWW = VLEN * CW;
    localparam int ARRW = VLEN * ROWW;
    localparam logic [RW-1:0] LAST_ROW = RW'(VLEN - 1);

    typedef struct packed {
        phase_e          phase;
        logic            done;
        logic [RW-1:0]   row;
        logic [VLEN-1:0] vec;
        logic [ARRW-1:0] cnt;
        logic [ROWW-1:0] rd;
    } state_t;

    state_t st_d, st_q;

    logic [VLEN*VLEN-1:0] prod_all;
    logic [VLEN-1:0]      prod_row;
    logic [ROWW-1:0]      row_cur;
    logic [ROWW-1:0]      row_nxt;

    sbop_expand #(.VLEN(VLEN)) u_expand (
        .vec  (st_q.vec),
        .prod (prod_all)
    );

    assign prod_row = prod_all[st_q.row*VLEN +: VLEN];
    assign row_cur  = st_q.cnt[st_q.row*ROWW +: ROWW];

    for (genvar j = 0; j < VLEN; j++) begin : g_lane
        sbop_lane #(.CW(CW)) u_lane (
            .cur (row_cur[j*CW +: CW]),
            .up  (prod_row[j]),
            .nxt (row_nxt[j*CW +: CW])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.rd   = st_q.cnt[rd_row*ROWW +: ROWW];
        if (clr) begin
            st_d.cnt   = '0;
            st_d.phase = PH_IDLE;
            st_d.row   = '0;
        end else if (st_q.phase == PH_RUN) begin
            st_d.cnt[st_q.row*ROWW +: ROWW] = row_nxt;
            if (st_q.row == LAST_ROW) begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
                st_d.row   = '0;
            end else begin
                st_d.row = st_q.row + 1'b1;
            end
        end else if (start) begin
            st_d.vec   = vec_in;
            st_d.phase = PH_RUN;
            st_d.row   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, done: 1'b0, row: '0, vec: '0, cnt: '0, rd: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = (st_q.phase == PH_RUN);
    assign done    = st_q.done;
    assign rd_data = st_q.rd;
endmodule

// File: rtl/sbop_corr_chk.sv
module sbop_corr_chk #(
    parameter int VLEN = 8,
    parameter int CW   = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clr,
    input logic                    start,
    input logic                    busy,
    input logic                    done,
    input logic [VLEN*CW-1:0]      rd_data
);
    localparam int RUNW = $clog2(VLEN + 2) + 1;

    logic [RUNW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + 1'b1;
        end else if (!done) begin
            run_q <= '0;
        end
    end

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_q == RUNW'(VLEN)));

    // R2
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUNW'(VLEN));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !clr) |=> busy);

    // R3
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    clr_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!busy && !done));

    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> ##2 (rd_data == '0));
endmodule

bind sbop_corr sbop_corr_chk #(.VLEN(VLEN), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .rd_data (rd_data)
);

// File: tb/sbop_corr_bench.sv
`timescale 1ns/1ps
module sbop_corr_bench;
    localparam int VLEN = 8;
    localparam int CW   = 8;
    localparam int NVEC = 6;
    localparam logic [VLEN-1:0] VEC_TAB [NVEC] = '{8'hFF, 8'hA5, 8'h00, 8'h0F, 8'h81, 8'h3C};

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                clr = 1'b0;
    logic                start = 1'b0;
    logic [VLEN-1:0]     vec_in = '0;
    logic                busy;
    logic                done;
    logic [2:0]          rd_row = '0;
    logic [VLEN*CW-1:0]  rd_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int mdl [VLEN][VLEN];

    sbop_corr u_sbop_corr (
        .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .vec_in(vec_in),
        .busy(busy), .done(done), .rd_row(rd_row), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic mdl_clear();
        for (int r = 0; r < VLEN; r++)
            for (int j = 0; j < VLEN; j++) mdl[r][j] = 0;
    endtask

    task automatic mdl_update(input logic [VLEN-1:0] v);
        for (int r = 0; r < VLEN; r++)
            for (int j = 0; j < VLEN; j++) begin
                mdl[r][j] += (v[r] == v[j]) ? 1 : -1;
                if (mdl[r][j] > 127) mdl[r][j] = 127;
                if (mdl[r][j] < -128) mdl[r][j] = -128;
            end
    endtask

    task automatic read_row(input int r, output logic [VLEN*CW-1:0] d);
        @(negedge clk);
        rd_row = 3'(r);
        @(posedge clk);
        #1 d = rd_data;
    endtask

    task automatic check_all(input string tag);
        logic [VLEN*CW-1:0] d;
        for (int r = 0; r < VLEN; r++) begin
            read_row(r, d);
            for (int j = 0; j < VLEN; j++)
                chk(tag, int'($signed(d[j*CW +: CW])), mdl[r][j]);
        end
    endtask

    task automatic run_update(input logic [VLEN-1:0] v, input bit inject);
        int nb;
        @(negedge clk);
        start = 1'b1;
        vec_in = v;
        @(negedge clk);
        start = 1'b0;
        nb = 0;
        while (busy && nb < 20) begin
            nb++;
            if (inject && nb == 3) begin
                start = 1'b1;
                vec_in = ~v;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk("R2 busy cycles", nb, 8);
        chk("R2 done after busy", int'(done), 1);
        @(negedge clk);
        chk("R2 done one cycle", int'(done), 0);
        chk(inject ? "R3 no second update" : "R2 idle after done", int'(busy), 0);
        mdl_update(v);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        mdl_clear();
    endtask

    initial begin
        logic [VLEN*CW-1:0] d;
        mdl_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8 busy", int'(busy), 0);
        chk("R8 done", int'(done), 0);
        chk("R8 rd_data", int'(rd_data == '0), 1);
        check_all("R8 counters");

        // R1 single update, R7 lane layout, R9 accumulation over the table
        for (int i = 0; i < NVEC; i++) begin
            run_update(VEC_TAB[i], 1'b0);
            check_all(i == 0 ? "R1 R7 first vector" : "R9 accumulate");
        end

        // R7 latency: the row changes in the cycle after the index changes
        read_row(0, d);
        @(negedge clk);
        rd_row = 3'd7;
        chk("R7 old row held before edge", int'(rd_data == d), 1);
        @(posedge clk);
        #1 chk("R7 new row after edge", int'($signed(rd_data[0 +: CW])), mdl[7][0]);

        // R3 start during busy ignored
        run_update(8'h5A, 1'b1);
        check_all("R3 counters");

        // R6 clear
        do_clear();
        check_all("R6 clear");

        // R6 clear in the middle of an update
        @(negedge clk);
        start = 1'b1;
        vec_in = 8'hC3;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R6 abort busy", int'(busy), 0);
        chk("R6 abort no done", int'(done), 0);
        @(negedge clk);
        chk("R6 abort no late done", int'(done), 0);
        mdl_clear();
        check_all("R6 abort counters");

        // R4 saturation at +127
        for (int i = 0; i < 130; i++) run_update(8'hFF, 1'b0);
        check_all("R4 upper limit");

        // R5 saturation at -128, R4 at +127 in the diagonal quadrants
        do_clear();
        for (int i = 0; i < 131; i++) run_update(8'h0F, 1'b0);
        read_row(0, d);
        chk("R5 lane at -128", int'($signed(d[7*CW +: CW])), -128);
        chk("R4 lane at +127", int'($signed(d[0 +: CW])), 127);
        check_all("R5 lower limit");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule